// File: doc/BRIEF.md
# Receive Phase Alignment Sequencer

This block walks a receiver through the steps that align its recovered parallel clock with the user receive clock when the receive elastic buffer is not used. It runs in the user receive clock domain. A single-cycle start request begins the sequence. The block pulses a receive datapath reset and waits for two conditions. The first is an optional clock-manager lock. The second is CDR lock, which also means a stable recovered clock. It then resets the delay aligner for a fixed window and raises the phase-align enable. After a settling wait it strobes set-phase for a fixed window. Last, it releases the delay-aligner disable and reports done.

Both lock flags come from other clock domains, so each passes through a short synchronizer before the controller uses it. A parameter removes the clock-manager wait for designs whose user clocks do not come from a clock manager. After done, the block keeps watching the locks it depends on. If one of them drops, it clears done, drops the alignment controls and starts again from the datapath reset.

Top module: `rx_phase_align_seq`

## Requirements
- R1: After reset, dly_disable_o is 1 and dp_reset_o, dly_reset_o, align_en_o, set_phase_o and done_o are all 0.
- R2: A start_i pulse in the idle state drives dp_reset_o high for exactly DP_RESET_CYCLES (default 4) consecutive cycles.
- R3: With the clock-manager wait enabled (SKIP_MGR_WAIT = 0), dly_reset_o stays 0 while mgr_locked_i is 0.
- R4: dly_reset_o stays 0 while cdr_locked_i is 0.
- R5: dly_reset_o is high for exactly DLY_RESET_CYCLES (default 20) consecutive cycles. During that time align_en_o and set_phase_o are 0.
- R6: align_en_o rises in the cycle in which dly_reset_o falls. It then stays high through the set-phase window and the whole done state.
- R7: align_en_o is high alone for exactly PRE_WAIT_CYCLES (default 32) cycles. Then set_phase_o is high for exactly SET_PHASE_CYCLES (default 32) cycles, and align_en_o stays high during that window.
- R8: In the cycle in which set_phase_o falls, done_o becomes 1 and dly_disable_o becomes 0.
- R9: With SKIP_MGR_WAIT = 1, mgr_locked_i has no effect. The sequence completes with that input held at 0, and a drop of that input does not clear done_o.
- R10: If a lock the block depends on drops while done_o is 1, done_o clears. In the same cycle align_en_o goes to 0, dly_disable_o to 1 and dp_reset_o to 1, and the sequence runs again once the locks return.
- R11: A start_i pulse while the sequence runs or while done_o is 1 is ignored. Window lengths are unchanged and done_o stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | User receive clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin the alignment sequence (accepted only when idle) |
| mgr_locked_i | input | 1 | Clock-manager lock flag, asynchronous |
| cdr_locked_i | input | 1 | CDR locked and recovered clock stable, asynchronous |
| dp_reset_o | output | 1 | Receive datapath reset |
| dly_reset_o | output | 1 | Delay-aligner reset |
| align_en_o | output | 1 | Phase-align enable |
| set_phase_o | output | 1 | Set-phase strobe |
| dly_disable_o | output | 1 | Delay-aligner disable |
| done_o | output | 1 | Alignment complete |

## Verification
The hardest case to reach is re-entry after completion. It needs a full pass through every window, then a lock loss while done is held. After that the block must be seen rebuilding the sequence from the datapath reset and not from a later step. The bench reaches this case by finishing a pass and then dropping each lock in turn. A second instance built with the clock-manager wait removed gets the same stimulus, and its manager lock is held low throughout, so one run shows that input being ignored next to the instance that honours it.

// File: rtl/rxpa_pkg.sv
// Package: shared state encoding for the receive phase alignment sequencer.
// Assumes: nothing beyond SystemVerilog-2017.
package rxpa_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_DP_RST   = 3'd1,
        ST_WAIT_MGR = 3'd2,
        ST_WAIT_CDR = 3'd3,
        ST_DLY_RST  = 3'd4,
        ST_PRE_WAIT = 3'd5,
        ST_SET_PH   = 3'd6,
        ST_DONE     = 3'd7
    } rxpa_state_e;

endpackage

// File: rtl/rxpa_lock_sync.sv
// Module: rxpa_lock_sync
// Brings the two asynchronous lock flags into the user clock domain through
// SYNC_STAGES flops each. It also removes the clock-manager flag when the
// design has no clock manager.
// Assumes: lock flags are level signals that stay stable for several cycles.
module rxpa_lock_sync #(
    parameter int SYNC_STAGES   = 2,
    parameter bit SKIP_MGR_WAIT = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mgr_locked_i,
    input  logic cdr_locked_i,
    output logic mgr_ok_o,
    output logic cdr_ok_o
);

    logic [SYNC_STAGES-1:0] mgr_q;
    logic [SYNC_STAGES-1:0] cdr_q;

    generate
        for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                // Purpose: first capture stage of each lock flag.
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        mgr_q[0] <= 1'b0;
                        cdr_q[0] <= 1'b0;
                    end else begin
                        mgr_q[0] <= mgr_locked_i;
                        cdr_q[0] <= cdr_locked_i;
                    end
                end
            end else begin : g_next
                // Purpose: further resolution stages of each lock flag.
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        mgr_q[i] <= 1'b0;
                        cdr_q[i] <= 1'b0;
                    end else begin
                        mgr_q[i] <= mgr_q[i-1];
                        cdr_q[i] <= cdr_q[i-1];
                    end
                end
            end
        end
    endgenerate

    assign mgr_ok_o = SKIP_MGR_WAIT ? 1'b1 : mgr_q[SYNC_STAGES-1];
    assign cdr_ok_o = cdr_q[SYNC_STAGES-1];

endmodule

// File: rtl/rxpa_window_timer.sv
// Module: rxpa_window_timer
// Down-counter for the fixed windows. A load sets it to (length - 1), and
// expired_o is high in the last cycle of the window.
// Assumes: every window is at least one cycle long.
module rxpa_window_timer #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             expired_o
);

    logic [CNT_W-1:0] cnt_q;

    // Purpose: load the window length or count down towards zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/rxpa_ctrl_fsm.sv
// Module: rxpa_ctrl_fsm
// Steps through the alignment sequence. It loads the window timer on entry
// to each timed step and advances when the timer expires or a lock condition
// is met. After completion it re-enters the datapath reset if a lock drops.
// Assumes: mgr_ok_i and cdr_ok_i are already synchronous to clk.
module rxpa_ctrl_fsm
    import rxpa_pkg::*;
#(
    parameter int DP_RESET_CYCLES  = 4,
    parameter int DLY_RESET_CYCLES = 20,
    parameter int PRE_WAIT_CYCLES  = 32,
    parameter int SET_PHASE_CYCLES = 32,
    parameter bit SKIP_MGR_WAIT    = 1'b0,
    parameter int CNT_W            = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             mgr_ok_i,
    input  logic             cdr_ok_i,
    input  logic             expired_i,
    output logic             load_o,
    output logic [CNT_W-1:0] load_val_o,
    output rxpa_state_e      state_o
);

    localparam logic [CNT_W-1:0] DP_LOAD  = CNT_W'(DP_RESET_CYCLES - 1);
    localparam logic [CNT_W-1:0] DLY_LOAD = CNT_W'(DLY_RESET_CYCLES - 1);
    localparam logic [CNT_W-1:0] PRE_LOAD = CNT_W'(PRE_WAIT_CYCLES - 1);
    localparam logic [CNT_W-1:0] SET_LOAD = CNT_W'(SET_PHASE_CYCLES - 1);

    rxpa_state_e state_q;
    rxpa_state_e state_d;
    logic        locks_ok;

    assign locks_ok = mgr_ok_i && cdr_ok_i;

    // Purpose: next-step selection and timer loading.
    always_comb begin
        state_d    = state_q;
        load_o     = 1'b0;
        load_val_o = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d    = ST_DP_RST;
                    load_o     = 1'b1;
                    load_val_o = DP_LOAD;
                end
            end
            ST_DP_RST: begin
                if (expired_i) begin
                    state_d = SKIP_MGR_WAIT ? ST_WAIT_CDR : ST_WAIT_MGR;
                end
            end
            ST_WAIT_MGR: begin
                if (mgr_ok_i) begin
                    state_d = ST_WAIT_CDR;
                end
            end
            ST_WAIT_CDR: begin
                if (locks_ok) begin
                    state_d    = ST_DLY_RST;
                    load_o     = 1'b1;
                    load_val_o = DLY_LOAD;
                end else if (!mgr_ok_i) begin
                    state_d = ST_WAIT_MGR;
                end
            end
            ST_DLY_RST: begin
                if (expired_i) begin
                    state_d    = ST_PRE_WAIT;
                    load_o     = 1'b1;
                    load_val_o = PRE_LOAD;
                end
            end
            ST_PRE_WAIT: begin
                if (expired_i) begin
                    state_d    = ST_SET_PH;
                    load_o     = 1'b1;
                    load_val_o = SET_LOAD;
                end
            end
            ST_SET_PH: begin
                if (expired_i) begin
                    state_d = ST_DONE;
                end
            end
            ST_DONE: begin
                if (!locks_ok) begin
                    state_d    = ST_DP_RST;
                    load_o     = 1'b1;
                    load_val_o = DP_LOAD;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Purpose: state register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign state_o = state_q;

endmodule

// File: rtl/rxpa_out_decode.sv
// Module: rxpa_out_decode
// Decodes the step into the six control outputs. The outputs depend only on
// the registered state, so each one changes right after the clock edge that
// changes the step.
// Assumes: state_i comes straight from a register.
module rxpa_out_decode
    import rxpa_pkg::*;
(
    input  rxpa_state_e state_i,
    output logic        dp_reset_o,
    output logic        dly_reset_o,
    output logic        align_en_o,
    output logic        set_phase_o,
    output logic        dly_disable_o,
    output logic        done_o
);

    // Purpose: per-step output levels.
    always_comb begin
        dp_reset_o    = (state_i == ST_DP_RST);
        dly_reset_o   = (state_i == ST_DLY_RST);
        align_en_o    = (state_i == ST_PRE_WAIT) || (state_i == ST_SET_PH) ||
                        (state_i == ST_DONE);
        set_phase_o   = (state_i == ST_SET_PH);
        dly_disable_o = (state_i != ST_DONE);
        done_o        = (state_i == ST_DONE);
    end

endmodule

// File: rtl/rx_phase_align_seq.sv
// Module: rx_phase_align_seq (top)
// Receive phase alignment sequencer for a receive path with the elastic buffer
// bypassed. It joins the lock synchronizer, the window timer, the control FSM
// and the output decoder.
// Assumes: clk is the user receive clock. All window lengths are at least 1.
module rx_phase_align_seq #(
    parameter int DP_RESET_CYCLES  = 4,
    parameter int DLY_RESET_CYCLES = 20,
    parameter int PRE_WAIT_CYCLES  = 32,
    parameter int SET_PHASE_CYCLES = 32,
    parameter int SYNC_STAGES      = 2,
    parameter bit SKIP_MGR_WAIT    = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic mgr_locked_i,
    input  logic cdr_locked_i,
    output logic dp_reset_o,
    output logic dly_reset_o,
    output logic align_en_o,
    output logic set_phase_o,
    output logic dly_disable_o,
    output logic done_o
);

    localparam int MAX_A   = (DP_RESET_CYCLES > DLY_RESET_CYCLES) ?
                             DP_RESET_CYCLES : DLY_RESET_CYCLES;
    localparam int MAX_B   = (PRE_WAIT_CYCLES > SET_PHASE_CYCLES) ?
                             PRE_WAIT_CYCLES : SET_PHASE_CYCLES;
    localparam int MAX_WIN = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W   = (MAX_WIN < 2) ? 1 : $clog2(MAX_WIN);

    logic                 mgr_ok;
    logic                 cdr_ok;
    logic                 tmr_load;
    logic [CNT_W-1:0]     tmr_val;
    logic                 tmr_expired;
    rxpa_pkg::rxpa_state_e state;

    rxpa_lock_sync #(
        .SYNC_STAGES   (SYNC_STAGES),
        .SKIP_MGR_WAIT (SKIP_MGR_WAIT)
    ) u_sync (
        .clk          (clk),
        .rst_n        (rst_n),
        .mgr_locked_i (mgr_locked_i),
        .cdr_locked_i (cdr_locked_i),
        .mgr_ok_o     (mgr_ok),
        .cdr_ok_o     (cdr_ok)
    );

    rxpa_window_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .expired_o  (tmr_expired)
    );

    rxpa_ctrl_fsm #(
        .DP_RESET_CYCLES  (DP_RESET_CYCLES),
        .DLY_RESET_CYCLES (DLY_RESET_CYCLES),
        .PRE_WAIT_CYCLES  (PRE_WAIT_CYCLES),
        .SET_PHASE_CYCLES (SET_PHASE_CYCLES),
        .SKIP_MGR_WAIT    (SKIP_MGR_WAIT),
        .CNT_W            (CNT_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .mgr_ok_i   (mgr_ok),
        .cdr_ok_i   (cdr_ok),
        .expired_i  (tmr_expired),
        .load_o     (tmr_load),
        .load_val_o (tmr_val),
        .state_o    (state)
    );

    rxpa_out_decode u_dec (
        .state_i       (state),
        .dp_reset_o    (dp_reset_o),
        .dly_reset_o   (dly_reset_o),
        .align_en_o    (align_en_o),
        .set_phase_o   (set_phase_o),
        .dly_disable_o (dly_disable_o),
        .done_o        (done_o)
    );

endmodule

// File: rtl/rx_phase_align_seq_chk.sv
// Module: rx_phase_align_seq_chk
// Checker bound to rx_phase_align_seq. It watches only the top-level ports and
// counts window lengths with its own counters.
module rx_phase_align_seq_chk #(
    parameter int DLY_RESET_CYCLES = 20,
    parameter int SET_PHASE_CYCLES = 32
) (
    input logic clk,
    input logic rst_n,
    input logic dp_reset_o,
    input logic dly_reset_o,
    input logic align_en_o,
    input logic set_phase_o,
    input logic dly_disable_o,
    input logic done_o
);

    localparam int W = $clog2(DLY_RESET_CYCLES + SET_PHASE_CYCLES + 2);

    logic [W-1:0] dly_run;
    logic [W-1:0] set_run;

    // Purpose: count consecutive high cycles of the two strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dly_run <= '0;
            set_run <= '0;
        end else begin
            dly_run <= dly_reset_o ? dly_run + 1'b1 : '0;
            set_run <= set_phase_o ? set_run + 1'b1 : '0;
        end
    end

    // R5
    dly_window_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dly_reset_o) |-> (dly_run == W'(DLY_RESET_CYCLES)));

    // R5
    dly_reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dly_reset_o |-> (!align_en_o && !set_phase_o));

    // R6
    align_after_dly_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dly_reset_o) |-> align_en_o);

    // R7
    setph_window_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(set_phase_o) |-> (set_run == W'(SET_PHASE_CYCLES)));

    // R7
    setph_needs_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_phase_o |-> align_en_o);

    // R8
    done_after_setph_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(set_phase_o) |-> (done_o && !dly_disable_o));

    // R10
    done_loss_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(done_o) |-> (dp_reset_o && !align_en_o && dly_disable_o));

    // R2
    dp_reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dp_reset_o |-> (!align_en_o && !done_o && dly_disable_o));

endmodule

bind rx_phase_align_seq rx_phase_align_seq_chk #(
    .DLY_RESET_CYCLES (DLY_RESET_CYCLES),
    .SET_PHASE_CYCLES (SET_PHASE_CYCLES)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .dp_reset_o    (dp_reset_o),
    .dly_reset_o   (dly_reset_o),
    .align_en_o    (align_en_o),
    .set_phase_o   (set_phase_o),
    .dly_disable_o (dly_disable_o),
    .done_o        (done_o)
);

// File: tb/rx_phase_align_seq_bench.sv
module rx_phase_align_seq_bench;

    localparam int DP_N  = 4;
    localparam int DLY_N = 20;
    localparam int PRE_N = 32;
    localparam int SET_N = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic mgr = 1'b0;
    logic cdr = 1'b0;
    logic mgr_s = 1'b0;

    logic dp_r, dly_r, al_en, set_ph, dly_dis, done;
    logic dp_r_s, dly_r_s, al_en_s, set_ph_s, dly_dis_s, done_s;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    rx_phase_align_seq u_rx_phase_align_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start), .mgr_locked_i(mgr),
        .cdr_locked_i(cdr), .dp_reset_o(dp_r), .dly_reset_o(dly_r),
        .align_en_o(al_en), .set_phase_o(set_ph), .dly_disable_o(dly_dis),
        .done_o(done)
    );

    rx_phase_align_seq #(.SKIP_MGR_WAIT(1'b1)) u_rx_phase_align_seq_skip (
        .clk(clk), .rst_n(rst_n), .start_i(start), .mgr_locked_i(mgr_s),
        .cdr_locked_i(cdr), .dp_reset_o(dp_r_s), .dly_reset_o(dly_r_s),
        .align_en_o(al_en_s), .set_phase_o(set_ph_s), .dly_disable_o(dly_dis_s),
        .done_o(done_s)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic sig(input int k);
        case (k)
            0: return dp_r;
            1: return dly_r;
            2: return al_en && !set_ph;
            3: return set_ph;
            4: return done;
            default: return done_s;
        endcase
    endfunction

    // wait at negedges until signal k equals v, up to lim cycles
    task automatic wait_sig(input int k, input logic v, input int lim, output bit ok);
        ok = 1'b0;
        for (int i = 0; i < lim; i++) begin
            if (sig(k) == v) begin
                ok = 1'b1;
                break;
            end
            @(negedge clk);
        end
    endtask

    // count consecutive cycles with signal k high, from the current negedge
    task automatic count_high(input int k, output int n);
        n = 0;
        while (sig(k) && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(dly_dis && !dp_r && !dly_r && !al_en && !set_ph && !done,
              "R1 idle outputs", {dly_dis, dp_r, dly_r, al_en, set_ph, done}, 6'b100000);
    endtask

    task automatic t_full_sequence();
        bit ok;
        int n;
        bit bad;
        mgr = 1'b0;
        cdr = 1'b1;
        pulse_start();
        wait_sig(0, 1'b1, 10, ok);
        count_high(0, n);
        check(n == DP_N, "R2 dp_reset length", n, DP_N);
        bad = 1'b0;
        for (int i = 0; i < 50; i++) begin
            if (dly_r) bad = 1'b1;
            @(negedge clk);
        end
        check(!bad, "R3 no delay reset without manager lock", bad, 0);
        mgr = 1'b1;
        cdr = 1'b0;
        bad = 1'b0;
        for (int i = 0; i < 50; i++) begin
            if (dly_r) bad = 1'b1;
            @(negedge clk);
        end
        check(!bad, "R4 no delay reset without CDR lock", bad, 0);
        cdr = 1'b1;
        wait_sig(1, 1'b1, 20, ok);
        check(ok, "R4 delay reset after CDR lock", ok, 1);
        check(!al_en && !set_ph, "R5 align/set low in delay reset", al_en, 0);
        count_high(1, n);
        check(n == DLY_N, "R5 delay reset length", n, DLY_N);
        check(al_en, "R6 align enable follows delay reset", al_en, 1);
        count_high(2, n);
        check(n == PRE_N, "R7 pre-wait length", n, PRE_N);
        count_high(3, n);
        check(n == SET_N, "R7 set-phase length", n, SET_N);
        check(done && !dly_dis, "R8 done and disable low", {done, dly_dis}, 2'b10);
        bad = 1'b0;
        for (int i = 0; i < 20; i++) begin
            if (!al_en || !done) bad = 1'b1;
            @(negedge clk);
        end
        check(!bad, "R6 align enable held in done", bad, 0);
        check(done_s, "R9 skip instance done with manager lock low", done_s, 1);
    endtask

    task automatic t_start_ignored_running();
        bit ok;
        int n;
        // both instances are done: drop CDR to restart them, then pulse start mid-run
        cdr = 1'b0;
        wait_sig(4, 1'b0, 10, ok);
        cdr = 1'b1;
        wait_sig(1, 1'b1, 40, ok);
        count_high(1, n);
        check(n == DLY_N, "R11 delay reset length on rerun", n, DLY_N);
        repeat (5) @(negedge clk);
        pulse_start();
        count_high(2, n);
        check(n == PRE_N - 6, "R11 pre-wait remainder unchanged by start", n, PRE_N - 6);
        count_high(3, n);
        check(n == SET_N, "R11 set-phase length after start", n, SET_N);
        pulse_start();
        repeat (10) @(negedge clk);
        check(done && al_en && !dp_r, "R11 start in done ignored", done, 1);
    endtask

    task automatic t_lock_loss();
        bit ok;
        cdr = 1'b0;
        wait_sig(4, 1'b0, 10, ok);
        check(ok, "R10 done clears on CDR loss", ok, 1);
        check(dp_r && !al_en && dly_dis, "R10 restart outputs",
              {dp_r, al_en, dly_dis}, 3'b101);
        cdr = 1'b1;
        wait_sig(4, 1'b1, 300, ok);
        check(ok, "R10 done again after relock", ok, 1);
        mgr = 1'b0;
        wait_sig(4, 1'b0, 10, ok);
        check(ok && dp_r, "R10 done clears on manager loss", ok, 1);
        check(done_s, "R9 skip instance unaffected by manager loss", done_s, 1);
        mgr = 1'b1;
        wait_sig(4, 1'b1, 300, ok);
        check(ok, "R10 done after manager relock", ok, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_full_sequence();
        t_start_ignored_running();
        t_lock_loss();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule